// File: doc/BRIEF.md
# Secure Security-Control Register Bank

This block is the secure-side configuration bank of a partitioned subsystem. It occupies a 4 KB window on a simple request bus: valid, write, address, write data and access size. Read data comes back one cycle after each read request. The bank holds the global security settings and drives them to outputs: the secure response mode and the two non-secure-callable flags.

The bank also gathers level interrupt lines from the peripheral, memory and memory-security protection controllers. Each line is registered into a status word at a fixed bit position. Enable words and one-cycle clear pulses go back out to those controllers. A combined interrupt is raised when an enabled memory-security expansion line is active. Identification bytes sit at the top of the window, and a parameter selects one byte of them.

The bank never signals an error. Writes to read-only or unmapped words are dropped. So are writes narrower than a word and unaligned writes. Narrow reads return the addressed lane of the word, shifted down to bit 0.

Top module: `secctl_bank`

## Requirements
- R1: After reset, every stored word reads 0, all configuration, enable, clear and select outputs are low, and bus_rvalid is low.
- R2: A word write to 0x010 keeps only bit 0, which drives resp_cfg_o. A word write to 0x014 keeps bits 1:0, which drive nsc_cfg_o. Both read back masked.
- R3: The peripheral status word at 0x020 registers the input levels one cycle after they are applied. Internal controller n (n = 0, 1) maps to bit n. APB expansion controller n maps to bit 4+n. AHB expansion controller n maps to bit 20+n. All other bits read 0.
- R4: The peripheral enable word at 0x028 keeps only the bits of mask 0x00F000F3. Each controller's enable output is driven from that controller's bit in the R3 layout.
- R5: A word write to 0x020+4 (0x024) works as follows. For one cycle it clears the written status bits, restricted to mask 0x00F000F3. For one cycle it pulses the clear output of each controller whose bit was written. Reading 0x024 returns 0.
- R6: The memory-protection status word at 0x01C maps mpc_irq[n] to bit n and mpcx_irq[n] to bit 16+n. A read issued in the same cycle that an input changes returns the value before the change.
- R7: The memory-security status word at 0x030 maps mscx_irq[n] to bit 16+n. The enable word at 0x038 stores all 32 bits. msc_irq_o is high exactly when status AND enable is nonzero.
- R8: A word write to 0x034 pulses msc_clear_o[n] for one cycle from bit 16+n of the written data. Reading 0x034 returns 0. A word write to 0x0D0 stores the data, and msc_ns_o[n] follows bit 16+n of it.
- R9: The bridge status word 0x040 always reads 0. The bridge enable word 0x048 keeps bits 31:16 only. Writes to 0x044 change nothing.
- R10: Words 0xFD0 to 0xFFC read one identification byte each, in this order: 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. With ID_VARIANT set, the byte at 0xFE8 reads 2B instead of 0B.
- R11: bus_size encodes 0 = byte, 1 = halfword, 2 = word. A read returns the word at the address with bits 1:0 cleared, shifted right by 8 times addr[1:0], then cut to the access width.
- R12: The following writes change no state: writes with bus_size other than 2, unaligned word writes, and writes to read-only or unmapped offsets (including 0x050, 0x090 and the identification words). Reads of unmapped offsets, 0x050 and 0x090 return 0.
- R13: bus_rvalid is high in exactly the cycle after each read request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| ppc_apb_irq | input | 2 | Internal peripheral controller interrupt levels |
| ppc_apbx_irq | input | NUM_APBX | APB expansion controller interrupt levels |
| ppc_ahbx_irq | input | NUM_AHBX | AHB expansion controller interrupt levels |
| mpc_irq | input | NUM_MPC | Memory-protection controller levels |
| mpcx_irq | input | NUM_MPCX | Expansion memory-protection controller levels |
| mscx_irq | input | NUM_MSC | Memory-security expansion levels |
| resp_cfg_o | output | 1 | Secure response mode |
| nsc_cfg_o | output | 2 | Non-secure-callable flags |
| ppc_apb_en_o | output | 2 | Interrupt enable, internal controllers |
| ppc_apbx_en_o | output | NUM_APBX | Interrupt enable, APB expansion controllers |
| ppc_ahbx_en_o | output | NUM_AHBX | Interrupt enable, AHB expansion controllers |
| ppc_apb_clr_o | output | 2 | Clear pulse, internal controllers |
| ppc_apbx_clr_o | output | NUM_APBX | Clear pulse, APB expansion controllers |
| ppc_ahbx_clr_o | output | NUM_AHBX | Clear pulse, AHB expansion controllers |
| msc_clear_o | output | NUM_MSC | Clear pulse, memory-security expansion |
| msc_ns_o | output | NUM_MSC | Non-secure select, memory-security expansion |
| msc_irq_o | output | 1 | Combined memory-security interrupt |

## Verification
The assertions assume a few things about the inputs. Every configuration output moves only as the result of a bus write. Reset holds bus_valid low. The interrupt inputs change at most once per cycle, so a rise of msc_irq_o traces back to a write or an input level in the previous cycle. The stimulus drives all inputs on the falling edge, with rst_n low and the bus idle during reset. Narrow and unaligned writes are issued deliberately, so the stability properties for dropped writes are actually exercised.

// File: rtl/secctl_pkg.sv
package secctl_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // word offsets that software depends on
    localparam logic [ADDR_W-1:0] OFF_RESP    = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_NSC     = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_MPC_ST  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_PPC_ST  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_PPC_CLR = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_PPC_EN  = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_MSC_ST  = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_MSC_CLR = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_MSC_EN  = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_BRG_ST  = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_BRG_CLR = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_BRG_EN  = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_MSC_NS  = 12'h0D0;

    localparam logic [DATA_W-1:0] PPC_MASK = 32'h00F0_00F3;
    localparam logic [DATA_W-1:0] BRG_MASK = 32'hFFFF_0000;

    localparam int PPC_APBX_BASE = 4;
    localparam int PPC_AHBX_BASE = 20;
    localparam int HI_BASE       = 16;
    localparam int ID_COUNT      = 12;

endpackage

// File: rtl/secctl_lvl_pack.sv
module secctl_lvl_pack
    import secctl_pkg::*;
#(
    parameter int NUM_APBX = 4,
    parameter int NUM_AHBX = 4,
    parameter int NUM_MPC  = 4,
    parameter int NUM_MPCX = 4,
    parameter int NUM_MSC  = 4
) (
    input  logic [1:0]          apb_i,
    input  logic [NUM_APBX-1:0] apbx_i,
    input  logic [NUM_AHBX-1:0] ahbx_i,
    input  logic [NUM_MPC-1:0]  mpc_i,
    input  logic [NUM_MPCX-1:0] mpcx_i,
    input  logic [NUM_MSC-1:0]  msc_i,
    output logic [DATA_W-1:0]   ppc_o,
    output logic [DATA_W-1:0]   mpc_o,
    output logic [DATA_W-1:0]   msc_o
);

    localparam int APBX_PAD = PPC_AHBX_BASE - PPC_APBX_BASE - NUM_APBX;
    localparam int AHBX_PAD = DATA_W - PPC_AHBX_BASE - NUM_AHBX;
    localparam int MPC_PAD  = HI_BASE - NUM_MPC;
    localparam int MPCX_PAD = DATA_W - HI_BASE - NUM_MPCX;
    localparam int MSC_PAD  = DATA_W - HI_BASE - NUM_MSC;

    // peripheral controllers: fixed positions, gaps read as zero
    assign ppc_o = {{AHBX_PAD{1'b0}}, ahbx_i,
                    {APBX_PAD{1'b0}}, apbx_i,
                    2'b00, apb_i};

    assign mpc_o = {{MPCX_PAD{1'b0}}, mpcx_i, {MPC_PAD{1'b0}}, mpc_i};

    assign msc_o = {{MSC_PAD{1'b0}}, msc_i, {HI_BASE{1'b0}}};

endmodule

// File: rtl/secctl_id_rom.sv
module secctl_id_rom
    import secctl_pkg::*;
#(
    parameter bit ID_VARIANT = 1'b0
) (
    input  logic [3:0] idx_i,
    output logic [7:0] byte_o
);

    localparam logic [7:0] REV_BYTE = ID_VARIANT ? 8'h2B : 8'h0B;

    always_comb begin
        case (idx_i)
            4'd0:    byte_o = 8'h04;
            4'd4:    byte_o = 8'h52;
            4'd5:    byte_o = 8'hB8;
            4'd6:    byte_o = REV_BYTE;
            4'd8:    byte_o = 8'h0D;
            4'd9:    byte_o = 8'hF0;
            4'd10:   byte_o = 8'h05;
            4'd11:   byte_o = 8'hB1;
            default: byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/secctl_rd_lane.sv
module secctl_rd_lane
    import secctl_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [1:0]        lane_i,
    input  acc_size_e         size_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] shifted;

    assign shifted = word_i >> {lane_i, 3'b000};

    always_comb begin
        case (size_i)
            SZ_BYTE: data_o = {24'h0, shifted[7:0]};
            SZ_HALF: data_o = {16'h0, shifted[15:0]};
            default: data_o = shifted;
        endcase
    end

endmodule

// File: rtl/secctl_bank.sv
module secctl_bank
    import secctl_pkg::*;
#(
    parameter int NUM_APBX   = 4,
    parameter int NUM_AHBX   = 4,
    parameter int NUM_MPC    = 4,
    parameter int NUM_MPCX   = 4,
    parameter int NUM_MSC    = 4,
    parameter bit ID_VARIANT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [11:0]         bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [1:0]          ppc_apb_irq,
    input  logic [NUM_APBX-1:0] ppc_apbx_irq,
    input  logic [NUM_AHBX-1:0] ppc_ahbx_irq,
    input  logic [NUM_MPC-1:0]  mpc_irq,
    input  logic [NUM_MPCX-1:0] mpcx_irq,
    input  logic [NUM_MSC-1:0]  mscx_irq,
    output logic                resp_cfg_o,
    output logic [1:0]          nsc_cfg_o,
    output logic [1:0]          ppc_apb_en_o,
    output logic [NUM_APBX-1:0] ppc_apbx_en_o,
    output logic [NUM_AHBX-1:0] ppc_ahbx_en_o,
    output logic [1:0]          ppc_apb_clr_o,
    output logic [NUM_APBX-1:0] ppc_apbx_clr_o,
    output logic [NUM_AHBX-1:0] ppc_ahbx_clr_o,
    output logic [NUM_MSC-1:0]  msc_clear_o,
    output logic [NUM_MSC-1:0]  msc_ns_o,
    output logic                msc_irq_o
);

    localparam logic [5:0] ID_PAGE  = 6'h3F;
    localparam logic [3:0] ID_FIRST = 4'h4;

    typedef struct packed {
        logic                resp;
        logic [1:0]          nsc;
        logic [DATA_W-1:0]   ppc_st;
        logic [DATA_W-1:0]   ppc_en;
        logic [DATA_W-1:0]   ppc_clr;
        logic [DATA_W-1:0]   mpc_st;
        logic [DATA_W-1:0]   msc_st;
        logic [DATA_W-1:0]   msc_en;
        logic [DATA_W-1:0]   msc_ns;
        logic [NUM_MSC-1:0]  msc_clr;
        logic [DATA_W-1:0]   brg_en;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [DATA_W-1:0] ppc_lvl, mpc_lvl, msc_lvl;
    logic [DATA_W-1:0] rd_word, rd_data;
    logic [ADDR_W-1:0] rd_off;
    logic [3:0]        id_idx;
    logic [7:0]        id_byte;
    logic              wr_ok, rd_req, in_id;

    secctl_lvl_pack #(
        .NUM_APBX (NUM_APBX),
        .NUM_AHBX (NUM_AHBX),
        .NUM_MPC  (NUM_MPC),
        .NUM_MPCX (NUM_MPCX),
        .NUM_MSC  (NUM_MSC)
    ) u_pack (
        .apb_i  (ppc_apb_irq),
        .apbx_i (ppc_apbx_irq),
        .ahbx_i (ppc_ahbx_irq),
        .mpc_i  (mpc_irq),
        .mpcx_i (mpcx_irq),
        .msc_i  (mscx_irq),
        .ppc_o  (ppc_lvl),
        .mpc_o  (mpc_lvl),
        .msc_o  (msc_lvl)
    );

    // request decode
    assign wr_ok  = bus_valid && bus_write &&
                    (acc_size_e'(bus_size) == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign rd_req = bus_valid && !bus_write;
    assign rd_off = {bus_addr[11:2], 2'b00};
    assign in_id  = (rd_off[11:6] == ID_PAGE) && (rd_off[5:2] >= ID_FIRST);
    assign id_idx = rd_off[5:2] - ID_FIRST;

    secctl_id_rom #(
        .ID_VARIANT (ID_VARIANT)
    ) u_id (
        .idx_i  (id_idx),
        .byte_o (id_byte)
    );

    // word selected for a read
    always_comb begin
        case (rd_off)
            OFF_RESP:   rd_word = {31'h0, bank_q.resp};
            OFF_NSC:    rd_word = {30'h0, bank_q.nsc};
            OFF_MPC_ST: rd_word = bank_q.mpc_st;
            OFF_PPC_ST: rd_word = bank_q.ppc_st;
            OFF_PPC_EN: rd_word = bank_q.ppc_en;
            OFF_MSC_ST: rd_word = bank_q.msc_st;
            OFF_MSC_EN: rd_word = bank_q.msc_en;
            OFF_BRG_EN: rd_word = bank_q.brg_en;
            OFF_MSC_NS: rd_word = bank_q.msc_ns;
            default:    rd_word = in_id ? {24'h0, id_byte} : '0;
        endcase
    end

    secctl_rd_lane u_lane (
        .word_i (rd_word),
        .lane_i (bus_addr[1:0]),
        .size_i (acc_size_e'(bus_size)),
        .data_o (rd_data)
    );

    // next-state computation
    always_comb begin
        bank_d         = bank_q;
        bank_d.ppc_st  = ppc_lvl;
        bank_d.mpc_st  = mpc_lvl;
        bank_d.msc_st  = msc_lvl;
        bank_d.ppc_clr = '0;
        bank_d.msc_clr = '0;
        bank_d.rvalid  = rd_req;
        bank_d.rdata   = rd_req ? rd_data : '0;

        if (wr_ok) begin
            case (bus_addr)
                OFF_RESP:    bank_d.resp = bus_wdata[0];
                OFF_NSC:     bank_d.nsc  = bus_wdata[1:0];
                OFF_PPC_CLR: begin
                    bank_d.ppc_clr = bus_wdata & PPC_MASK;
                    bank_d.ppc_st  = ppc_lvl & ~(bus_wdata & PPC_MASK);
                end
                OFF_PPC_EN:  bank_d.ppc_en  = bus_wdata & PPC_MASK;
                OFF_MSC_CLR: bank_d.msc_clr = bus_wdata[HI_BASE +: NUM_MSC];
                OFF_MSC_EN:  bank_d.msc_en  = bus_wdata;
                OFF_MSC_NS:  bank_d.msc_ns  = bus_wdata;
                OFF_BRG_EN:  bank_d.brg_en  = bus_wdata & BRG_MASK;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // outputs
    assign bus_rdata  = bank_q.rdata;
    assign bus_rvalid = bank_q.rvalid;
    assign resp_cfg_o = bank_q.resp;
    assign nsc_cfg_o  = bank_q.nsc;
    assign msc_clear_o = bank_q.msc_clr;
    assign msc_ns_o    = bank_q.msc_ns[HI_BASE +: NUM_MSC];
    assign msc_irq_o   = |(bank_q.msc_st & bank_q.msc_en);

    assign ppc_apb_en_o  = bank_q.ppc_en[1:0];
    assign ppc_apb_clr_o = bank_q.ppc_clr[1:0];

    for (genvar n = 0; n < NUM_APBX; n++) begin : g_apbx
        assign ppc_apbx_en_o[n]  = bank_q.ppc_en[PPC_APBX_BASE + n];
        assign ppc_apbx_clr_o[n] = bank_q.ppc_clr[PPC_APBX_BASE + n];
    end

    for (genvar n = 0; n < NUM_AHBX; n++) begin : g_ahbx
        assign ppc_ahbx_en_o[n]  = bank_q.ppc_en[PPC_AHBX_BASE + n];
        assign ppc_ahbx_clr_o[n] = bank_q.ppc_clr[PPC_AHBX_BASE + n];
    end

endmodule

// File: rtl/secctl_bank_chk.sv
module secctl_bank_chk #(
    parameter int NUM_APBX = 4,
    parameter int NUM_AHBX = 4,
    parameter int NUM_MSC  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [11:0]         bus_addr,
    input logic [1:0]          bus_size,
    input logic [31:0]         bus_rdata,
    input logic                bus_rvalid,
    input logic                resp_cfg_o,
    input logic [1:0]          nsc_cfg_o,
    input logic [1:0]          ppc_apb_clr_o,
    input logic [NUM_APBX-1:0] ppc_apbx_clr_o,
    input logic [NUM_AHBX-1:0] ppc_ahbx_clr_o,
    input logic [NUM_MSC-1:0]  msc_clear_o,
    input logic [NUM_MSC-1:0]  msc_ns_o,
    input logic [NUM_MSC-1:0]  mscx_irq,
    input logic                msc_irq_o
);

    // R13
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R13
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    // R2
    resp_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_cfg_o) |-> $past(bus_valid && bus_write));

    // R5
    ppc_clr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{ppc_apb_clr_o, ppc_apbx_clr_o, ppc_ahbx_clr_o}) |->
            $past(bus_valid && bus_write && bus_addr == 12'h024));

    // R8
    msc_clr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|msc_clear_o) |-> $past(bus_valid && bus_write && bus_addr == 12'h034));

    // R7
    msc_irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msc_irq_o) |-> ($past(bus_valid && bus_write) || $past(|mscx_irq)));

    // R9
    brg_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[11:2] == 10'h010) |=> (bus_rdata == 32'h0));

    // R12
    narrow_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != 2'd2) |=>
            ($stable(resp_cfg_o) && $stable(nsc_cfg_o) && $stable(msc_ns_o)));

endmodule

bind secctl_bank secctl_bank_chk #(
    .NUM_APBX (NUM_APBX),
    .NUM_AHBX (NUM_AHBX),
    .NUM_MSC  (NUM_MSC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_addr       (bus_addr),
    .bus_size       (bus_size),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .resp_cfg_o     (resp_cfg_o),
    .nsc_cfg_o      (nsc_cfg_o),
    .ppc_apb_clr_o  (ppc_apb_clr_o),
    .ppc_apbx_clr_o (ppc_apbx_clr_o),
    .ppc_ahbx_clr_o (ppc_ahbx_clr_o),
    .msc_clear_o    (msc_clear_o),
    .msc_ns_o       (msc_ns_o),
    .mscx_irq       (mscx_irq),
    .msc_irq_o      (msc_irq_o)
);

// File: tb/sim_secctl_bank.sv
module sim_secctl_bank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, v_rdata;
    logic        bus_rvalid, v_rvalid;
    logic [1:0]  ppc_apb_irq = '0;
    logic [3:0]  ppc_apbx_irq = '0;
    logic [3:0]  ppc_ahbx_irq = '0;
    logic [3:0]  mpc_irq = '0;
    logic [3:0]  mpcx_irq = '0;
    logic [3:0]  mscx_irq = '0;

    logic        resp_cfg_o, msc_irq_o;
    logic [1:0]  nsc_cfg_o, ppc_apb_en_o, ppc_apb_clr_o;
    logic [3:0]  ppc_apbx_en_o, ppc_ahbx_en_o, ppc_apbx_clr_o, ppc_ahbx_clr_o;
    logic [3:0]  msc_clear_o, msc_ns_o;

    logic        v_resp, v_mirq;
    logic [1:0]  v_nsc, v_apb_en, v_apb_clr;
    logic [3:0]  v_apbx_en, v_ahbx_en, v_apbx_clr, v_ahbx_clr, v_mclr, v_mns;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    secctl_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ppc_apb_irq(ppc_apb_irq), .ppc_apbx_irq(ppc_apbx_irq), .ppc_ahbx_irq(ppc_ahbx_irq),
        .mpc_irq(mpc_irq), .mpcx_irq(mpcx_irq), .mscx_irq(mscx_irq),
        .resp_cfg_o(resp_cfg_o), .nsc_cfg_o(nsc_cfg_o),
        .ppc_apb_en_o(ppc_apb_en_o), .ppc_apbx_en_o(ppc_apbx_en_o), .ppc_ahbx_en_o(ppc_ahbx_en_o),
        .ppc_apb_clr_o(ppc_apb_clr_o), .ppc_apbx_clr_o(ppc_apbx_clr_o), .ppc_ahbx_clr_o(ppc_ahbx_clr_o),
        .msc_clear_o(msc_clear_o), .msc_ns_o(msc_ns_o), .msc_irq_o(msc_irq_o)
    );

    // second copy with the alternate identification byte
    secctl_bank #(.ID_VARIANT(1'b1)) u_var (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(v_rdata), .bus_rvalid(v_rvalid),
        .ppc_apb_irq(ppc_apb_irq), .ppc_apbx_irq(ppc_apbx_irq), .ppc_ahbx_irq(ppc_ahbx_irq),
        .mpc_irq(mpc_irq), .mpcx_irq(mpcx_irq), .mscx_irq(mscx_irq),
        .resp_cfg_o(v_resp), .nsc_cfg_o(v_nsc),
        .ppc_apb_en_o(v_apb_en), .ppc_apbx_en_o(v_apbx_en), .ppc_ahbx_en_o(v_ahbx_en),
        .ppc_apb_clr_o(v_apb_clr), .ppc_apbx_clr_o(v_apbx_clr), .ppc_ahbx_clr_o(v_ahbx_clr),
        .msc_clear_o(v_mclr), .msc_ns_o(v_mns), .msc_irq_o(v_mirq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // all bus tasks start and end on a falling edge
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        check("R13", "rvalid after read", {31'h0, bus_rvalid}, 32'h1);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a,
                          input logic [1:0] sz, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, sz, d);
        check(req, $sformatf("read %h", a), d, exp);
    endtask

    function automatic logic [7:0] id_expect(input int i, input bit variant);
        case (i)
            0: return 8'h04;  4: return 8'h52;  5: return 8'hB8;
            6: return variant ? 8'h2B : 8'h0B;
            8: return 8'h0D;  9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    task automatic t_reset();
        check("R1", "resp_cfg_o", {31'h0, resp_cfg_o}, 32'h0);
        check("R1", "nsc_cfg_o", {30'h0, nsc_cfg_o}, 32'h0);
        check("R1", "enables", {20'h0, ppc_apb_en_o, ppc_apbx_en_o, ppc_ahbx_en_o, 2'b0}, 32'h0);
        check("R1", "msc outputs", {23'h0, msc_ns_o, msc_clear_o, msc_irq_o}, 32'h0);
        check("R1", "rvalid idle", {31'h0, bus_rvalid}, 32'h0);
        rd_chk("R1", 12'h010, 2'd2, 32'h0);
        rd_chk("R1", 12'h028, 2'd2, 32'h0);
        rd_chk("R1", 12'h048, 2'd2, 32'h0);
    endtask

    task automatic t_cfg();
        bus_wr(12'h010, 32'hFFFF_FFFF, 2'd2);
        check("R2", "resp_cfg_o set", {31'h0, resp_cfg_o}, 32'h1);
        check("R13", "no rvalid on write", {31'h0, bus_rvalid}, 32'h0);
        rd_chk("R2", 12'h010, 2'd2, 32'h1);
        bus_wr(12'h014, 32'hFFFF_FFFF, 2'd2);
        check("R2", "nsc_cfg_o", {30'h0, nsc_cfg_o}, 32'h3);
        rd_chk("R2", 12'h014, 2'd2, 32'h3);
        bus_wr(12'h014, 32'h0000_0002, 2'd2);
        check("R2", "nsc_cfg_o=2", {30'h0, nsc_cfg_o}, 32'h2);
    endtask

    task automatic t_ppc_status();
        ppc_apb_irq = 2'b10; ppc_apbx_irq = 4'b0101; ppc_ahbx_irq = 4'b1000;
        @(negedge clk);
        rd_chk("R3", 12'h020, 2'd2, 32'h0080_0052);
        ppc_apb_irq = 2'b01; ppc_apbx_irq = 4'b1000; ppc_ahbx_irq = 4'b0001;
        @(negedge clk);
        rd_chk("R3", 12'h020, 2'd2, 32'h0010_0081);
    endtask

    task automatic t_ppc_en();
        bus_wr(12'h028, 32'hFFFF_FFFF, 2'd2);
        check("R4", "enable outs all", {20'h0, ppc_apb_en_o, ppc_apbx_en_o, ppc_ahbx_en_o, 2'b0},
              {20'h0, 2'b11, 4'hF, 4'hF, 2'b0});
        rd_chk("R4", 12'h028, 2'd2, 32'h00F0_00F3);
        bus_wr(12'h028, 32'h0010_0022, 2'd2);
        check("R4", "enable outs partial", {20'h0, ppc_apb_en_o, ppc_apbx_en_o, ppc_ahbx_en_o, 2'b0},
              {20'h0, 2'b10, 4'b0010, 4'b0001, 2'b0});
    endtask

    task automatic t_ppc_clr();
        ppc_apb_irq = 2'b10; ppc_apbx_irq = 4'b0101; ppc_ahbx_irq = 4'b1000;
        @(negedge clk);
        bus_wr(12'h024, 32'h0080_0006, 2'd2);
        check("R5", "clear pulses", {20'h0, ppc_apb_clr_o, ppc_apbx_clr_o, ppc_ahbx_clr_o, 2'b0},
              {20'h0, 2'b10, 4'b0000, 4'b1000, 2'b0});
        rd_chk("R5", 12'h020, 2'd2, 32'h0000_0050);
        check("R5", "clear pulse ends", {24'h0, ppc_apb_clr_o, ppc_apbx_clr_o, ppc_ahbx_clr_o},
              32'h0);
        rd_chk("R5", 12'h020, 2'd2, 32'h0080_0052);
        rd_chk("R5", 12'h024, 2'd2, 32'h0);
    endtask

    task automatic t_mpc();
        logic [31:0] d;
        mpc_irq = 4'b0011; mpcx_irq = 4'b0100;
        bus_rd(12'h01C, 2'd2, d);
        check("R6", "read during change", d, 32'h0);
        rd_chk("R6", 12'h01C, 2'd2, 32'h0004_0003);
    endtask

    task automatic t_msc();
        mscx_irq = 4'b0010;
        @(negedge clk);
        check("R7", "irq without enable", {31'h0, msc_irq_o}, 32'h0);
        rd_chk("R7", 12'h030, 2'd2, 32'h0002_0000);
        bus_wr(12'h038, 32'h0002_0000, 2'd2);
        check("R7", "irq enabled", {31'h0, msc_irq_o}, 32'h1);
        rd_chk("R7", 12'h038, 2'd2, 32'h0002_0000);
        mscx_irq = 4'b0000;
        @(negedge clk);
        check("R7", "irq drops with input", {31'h0, msc_irq_o}, 32'h0);
    endtask

    task automatic t_msc_clr_ns();
        bus_wr(12'h034, 32'h000A_0005, 2'd2);
        check("R8", "msc clear pulse", {28'h0, msc_clear_o}, 32'hA);
        rd_chk("R8", 12'h034, 2'd2, 32'h0);
        check("R8", "msc clear ends", {28'h0, msc_clear_o}, 32'h0);
        bus_wr(12'h0D0, 32'h0005_1234, 2'd2);
        check("R8", "msc_ns_o", {28'h0, msc_ns_o}, 32'h5);
        rd_chk("R8", 12'h0D0, 2'd2, 32'h0005_1234);
    endtask

    task automatic t_bridge();
        bus_wr(12'h048, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R9", 12'h048, 2'd2, 32'hFFFF_0000);
        bus_wr(12'h044, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R9", 12'h048, 2'd2, 32'hFFFF_0000);
        bus_wr(12'h040, 32'h0000_0123, 2'd2);
        rd_chk("R9", 12'h040, 2'd2, 32'h0);
    endtask

    task automatic t_id();
        for (int i = 0; i < 12; i++) begin
            rd_chk("R10", 12'hFD0 + 12'(4 * i), 2'd2, {24'h0, id_expect(i, 1'b0)});
        end
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'hFE8; bus_size = 2'd2;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R10", "variant byte", v_rdata, {24'h0, id_expect(6, 1'b1)});
    endtask

    task automatic t_subword();
        rd_chk("R11", 12'h0D1, 2'd0, 32'h12);
        rd_chk("R11", 12'h0D2, 2'd0, 32'h05);
        rd_chk("R11", 12'h0D2, 2'd1, 32'h0005);
        rd_chk("R11", 12'h0D0, 2'd1, 32'h1234);
        rd_chk("R11", 12'h0D3, 2'd0, 32'h00);
        rd_chk("R11", 12'hFE4, 2'd0, 32'hB8);
    endtask

    task automatic t_drops();
        bus_wr(12'h010, 32'h0, 2'd0);
        check("R12", "byte write ignored", {31'h0, resp_cfg_o}, 32'h1);
        bus_wr(12'h0D0, 32'h0, 2'd1);
        rd_chk("R12", 12'h0D0, 2'd2, 32'h0005_1234);
        bus_wr(12'h016, 32'h0, 2'd2);
        check("R12", "unaligned write ignored", {30'h0, nsc_cfg_o}, 32'h2);
        ppc_apb_irq = '0; ppc_apbx_irq = '0; ppc_ahbx_irq = '0;
        @(negedge clk);
        bus_wr(12'h020, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R12", 12'h020, 2'd2, 32'h0);
        bus_wr(12'hFD0, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R12", 12'hFD0, 2'd2, 32'h04);
        bus_wr(12'h050, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R12", 12'h050, 2'd2, 32'h0);
        bus_wr(12'h090, 32'hFFFF_FFFF, 2'd2);
        rd_chk("R12", 12'h090, 2'd2, 32'h0);
        rd_chk("R12", 12'h100, 2'd2, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_ppc_status();
        t_ppc_en();
        t_ppc_clr();
        t_mpc();
        t_msc();
        t_msc_clr_ns();
        t_bridge();
        t_id();
        t_subword();
        t_drops();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule